// File: doc/BRIEF.md
# Disk Record Field Writer

This block writes a single record onto a moving disk surface as a serial stream of flux-transition pulses. On a start request it switches on the write and erase gates and, from the very next clock, emits a run of zero preamble words, a sync word, the record's content words read from a small memory port, and a closing run of zero postamble words. Every bit cell carries a clock transition at its start; a 1 bit adds a second transition at mid-cell.

The caller states whether the record is the first one in its sector (long preamble, gates freshly switched on) or a record that follows another (short preamble). Content words come from consecutive addresses beginning at the given start address and are fetched one word ahead, so the cell rhythm never stretches or shrinks at a word boundary. When the last postamble cell ends, a one-cycle done pulse appears and the gates switch off, unless the caller holds them on to continue with a further record.

Top module: `disk_field_writer`

## Requirements
- R1: During and straight after reset, both gates, the transition output, the done output and the memory read strobe are low.
- R2: A start accepted while idle raises the write gate and the erase gate on the next clock, and the first clock transition appears in that same cycle; both gates stay high for the whole record.
- R3: Each bit cell lasts CELL_CLKS clocks: a one-cycle transition pulse at cell offset 0, a second one-cycle pulse at offset CELL_CLKS/2 only when the bit is 1, and no pulse at any other offset.
- R4: The record opens with 34 zero words when the first-record input is 1 at start, and with 3 zero words when it is 0.
- R5: Right after the preamble comes one sync word of value 16'h0001 (fifteen zeros, then a single 1 as the last bit sent).
- R6: After the sync word come count_i content words, read from addresses addr_i, addr_i+1, ... (wrapping), each sent most significant bit first, with no cell added or dropped between words; a count of 0 sends no content word.
- R7: The record closes with 5 zero postamble words.
- R8: In the cycle after the last postamble cell, done_o is high for exactly one cycle and no transition is emitted; the gates are then low if hold_i was 0 at that final edge, or stay high if it was 1 and fall one cycle after hold_i is seen low.
- R9: A start request while a record is being written is ignored: the stream in progress continues unchanged.
- R10: Each content word is fetched by a one-cycle mem_rd_o pulse with its address on mem_addr_o, one read per content word; the memory presents the data on mem_data_i in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to write one record (taken when idle) |
| first_i | input | 1 | 1: first record of the sector (long preamble) |
| count_i | input | CNT_W | Number of content words |
| addr_i | input | ADDR_W | Address of the first content word |
| hold_i | input | 1 | Keep the gates on after this record |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_data_i | input | WORD_W | Read data, valid the cycle after the strobe |
| wr_gate_o | output | 1 | Write gate to the head |
| erase_gate_o | output | 1 | Erase gate to the head |
| flux_o | output | 1 | One-cycle pulse per flux transition |
| done_o | output | 1 | One-cycle pulse when the record is complete |

## Verification
Counting from the clock edge that accepts a start, the gates and the first transition pulse are due one cycle later, and the pulse for bit b of word w sits at cycle 1 + (16*w + b)*CELL_CLKS plus 0 or CELL_CLKS/2. The done pulse is due at cycle 16*W*CELL_CLKS + 1, where W counts preamble, sync, content and postamble words, and gates released by hold_i fall one cycle after the edge that sees it low. The bench drives inputs and samples every output on the falling edge, stepping through each expected cycle of the record and comparing the transition output against a stream built from the bench's own memory image, while a bench memory model answers each read strobe one cycle later and logs the address.

// File: rtl/drw_pkg.sv
package drw_pkg;

    // Segment of the record that the word in the shifter belongs to.
    typedef enum logic [1:0] {
        SEG_PRE  = 2'd0,
        SEG_SYNC = 2'd1,
        SEG_DATA = 2'd2,
        SEG_POST = 2'd3
    } seg_e;

endpackage

// File: rtl/drw_cell_timer.sv
module drw_cell_timer #(
    parameter int CELL_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic cell_first_o,
    output logic cell_mid_o,
    output logic cell_last_o
);
    localparam int PH_W = (CELL_CLKS > 2) ? $clog2(CELL_CLKS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CELL_CLKS - 1);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(CELL_CLKS / 2);

    logic [PH_W-1:0] phase_d, phase_q;

    // Phase rests at zero while idle so that the first run cycle is a cell start.
    always_comb begin
        phase_d = '0;
        if (run_i) begin
            if (phase_q == PH_LAST) begin
                phase_d = '0;
            end else begin
                phase_d = phase_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign cell_first_o = (phase_q == '0);
    assign cell_mid_o   = (phase_q == PH_MID);
    assign cell_last_o  = (phase_q == PH_LAST);

endmodule

// File: rtl/drw_shifter.sv
module drw_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              adv_i,
    output logic              bit_o,
    output logic              word_last_o
);
    localparam int IDX_W = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [IDX_W-1:0]  idx;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.sh  = word_i;
            s_d.idx = IDX_W'(WORD_W - 1);
        end else if (adv_i) begin
            s_d.sh  = {s_q.sh[WORD_W-2:0], 1'b0};
            s_d.idx = s_q.idx - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Most significant bit leaves first.
    assign bit_o       = s_q.sh[WORD_W-1];
    assign word_last_o = (s_q.idx == '0);

endmodule

// File: rtl/drw_seq.sv
module drw_seq
    import drw_pkg::*;
#(
    parameter int          WORD_W          = 16,
    parameter int          ADDR_W          = 8,
    parameter int          CNT_W           = 8,
    parameter int          FIRST_PRE_WORDS = 34,
    parameter int          LATER_PRE_WORDS = 3,
    parameter int          POST_WORDS      = 5,
    parameter int unsigned SYNC_WORD       = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              first_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              hold_i,
    input  logic              cell_last_i,
    input  logic              word_last_i,
    output logic              run_o,
    output logic              gates_o,
    output logic              done_o,
    output logic              load_o,
    output logic [WORD_W-1:0] load_word_o,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [WORD_W-1:0] mem_data_i
);
    localparam int REM_W = $clog2(FIRST_PRE_WORDS + LATER_PRE_WORDS + POST_WORDS + (1 << CNT_W)) + 1;
    localparam logic [REM_W-1:0]  REM_ONE   = REM_W'(1);
    localparam logic [REM_W-1:0]  REM_FIRST = REM_W'(FIRST_PRE_WORDS);
    localparam logic [REM_W-1:0]  REM_LATER = REM_W'(LATER_PRE_WORDS);
    localparam logic [REM_W-1:0]  REM_POST  = REM_W'(POST_WORDS);
    localparam logic [WORD_W-1:0] SYNC_PAT  = WORD_W'(SYNC_WORD);

    typedef struct packed {
        logic              run;
        logic              gates;
        logic              done;
        seg_e              seg;
        logic [REM_W-1:0]  rem;      // words left in segment, current included
        logic [CNT_W-1:0]  dcnt;     // content word count of this record
        logic [ADDR_W-1:0] addr;     // next content address to fetch
        logic [WORD_W-1:0] pref;     // prefetched content word
        logic              pend;     // read data arrives this cycle
        logic              rd;
        logic [ADDR_W-1:0] rd_addr;
    } seq_t;

    seq_t s_d, s_q;

    logic             boundary;
    logic             final_word;
    seg_e             nseg;
    logic [REM_W-1:0] nrem;

    assign boundary   = s_q.run && cell_last_i && word_last_i;
    assign final_word = (s_q.seg == SEG_POST) && (s_q.rem == REM_ONE);

    always_comb begin
        s_d          = s_q;
        s_d.done     = 1'b0;
        s_d.rd       = 1'b0;
        s_d.pend     = s_q.rd;
        load_o       = 1'b0;
        load_word_o  = '0;
        nseg         = s_q.seg;
        nrem         = s_q.rem;

        if (s_q.pend) begin
            s_d.pref = mem_data_i;
        end

        if (!s_q.run) begin
            // Idle: held gates stay on only while hold_i stays high.
            s_d.gates = s_q.gates & hold_i;
            if (start_i) begin
                s_d.run   = 1'b1;
                s_d.gates = 1'b1;
                s_d.seg   = SEG_PRE;
                s_d.rem   = first_i ? REM_FIRST : REM_LATER;
                s_d.dcnt  = count_i;
                s_d.addr  = addr_i;
                load_o    = 1'b1;
            end
        end else if (boundary) begin
            if (final_word) begin
                s_d.run   = 1'b0;
                s_d.done  = 1'b1;
                s_d.gates = hold_i;
            end else begin
                if (s_q.rem != REM_ONE) begin
                    nrem = s_q.rem - 1'b1;
                end else begin
                    case (s_q.seg)
                        SEG_PRE: begin
                            nseg = SEG_SYNC;
                            nrem = REM_ONE;
                        end
                        SEG_SYNC: begin
                            if (s_q.dcnt != '0) begin
                                nseg = SEG_DATA;
                                nrem = REM_W'(s_q.dcnt);
                            end else begin
                                nseg = SEG_POST;
                                nrem = REM_POST;
                            end
                        end
                        default: begin
                            nseg = SEG_POST;
                            nrem = REM_POST;
                        end
                    endcase
                end

                s_d.seg = nseg;
                s_d.rem = nrem;
                load_o  = 1'b1;
                case (nseg)
                    SEG_SYNC: load_word_o = SYNC_PAT;
                    SEG_DATA: load_word_o = s_q.pref;
                    default:  load_word_o = '0;
                endcase

                // Fetch one word ahead when the word after this one is content.
                if (((nseg == SEG_SYNC) && (s_q.dcnt != '0)) ||
                    ((nseg == SEG_DATA) && (nrem != REM_ONE))) begin
                    s_d.rd      = 1'b1;
                    s_d.rd_addr = s_q.addr;
                    s_d.addr    = s_q.addr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o      = s_q.run;
    assign gates_o    = s_q.gates;
    assign done_o     = s_q.done;
    assign mem_rd_o   = s_q.rd;
    assign mem_addr_o = s_q.rd_addr;

endmodule

// File: rtl/disk_field_writer.sv
module disk_field_writer #(
    parameter int          WORD_W          = 16,
    parameter int          ADDR_W          = 8,
    parameter int          CNT_W           = 8,
    parameter int          CELL_CLKS       = 8,
    parameter int          FIRST_PRE_WORDS = 34,
    parameter int          LATER_PRE_WORDS = 3,
    parameter int          POST_WORDS      = 5,
    parameter int unsigned SYNC_WORD       = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              first_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              hold_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [WORD_W-1:0] mem_data_i,
    output logic              wr_gate_o,
    output logic              erase_gate_o,
    output logic              flux_o,
    output logic              done_o
);
    logic              running;
    logic              gates;
    logic              cell_first, cell_mid, cell_last;
    logic              load;
    logic [WORD_W-1:0] load_word;
    logic              cur_bit;
    logic              word_last;

    drw_cell_timer #(
        .CELL_CLKS (CELL_CLKS)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (running),
        .cell_first_o (cell_first),
        .cell_mid_o   (cell_mid),
        .cell_last_o  (cell_last)
    );

    drw_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .word_i      (load_word),
        .adv_i       (running && cell_last),
        .bit_o       (cur_bit),
        .word_last_o (word_last)
    );

    drw_seq #(
        .WORD_W          (WORD_W),
        .ADDR_W          (ADDR_W),
        .CNT_W           (CNT_W),
        .FIRST_PRE_WORDS (FIRST_PRE_WORDS),
        .LATER_PRE_WORDS (LATER_PRE_WORDS),
        .POST_WORDS      (POST_WORDS),
        .SYNC_WORD       (SYNC_WORD)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .first_i     (first_i),
        .count_i     (count_i),
        .addr_i      (addr_i),
        .hold_i      (hold_i),
        .cell_last_i (cell_last),
        .word_last_i (word_last),
        .run_o       (running),
        .gates_o     (gates),
        .done_o      (done_o),
        .load_o      (load),
        .load_word_o (load_word),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .mem_data_i  (mem_data_i)
    );

    // Clock transition at every cell start, data transition at mid-cell for a 1.
    assign flux_o       = running && (cell_first || (cell_mid && cur_bit));
    assign wr_gate_o    = gates;
    assign erase_gate_o = gates;

endmodule

// File: rtl/drw_checker.sv
module drw_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic hold_i,
    input logic running,
    input logic wr_gate_o,
    input logic erase_gate_o,
    input logic flux_o,
    input logic done_o,
    input logic mem_rd_o
);
    p_start_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && start_i) |=> (wr_gate_o && erase_gate_o && flux_o));

    p_flux_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flux_o |-> (wr_gate_o && erase_gate_o));

    p_flux_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flux_o |=> !flux_o);

    p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!flux_o && !running));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (wr_gate_o == $past(hold_i)));

    p_rd_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);

    p_rd_running_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> running);

endmodule

bind disk_field_writer drw_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .hold_i       (hold_i),
    .running      (running),
    .wr_gate_o    (wr_gate_o),
    .erase_gate_o (erase_gate_o),
    .flux_o       (flux_o),
    .done_o       (done_o),
    .mem_rd_o     (mem_rd_o)
);

// File: tb/tb_disk_field_writer.sv
module tb_disk_field_writer;
    localparam int CELL  = 8;
    localparam int WCELL = 16 * CELL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        first_i = 1'b0;
    logic [7:0]  count_i = '0;
    logic [7:0]  addr_i = '0;
    logic        hold_i = 1'b0;
    logic        mem_rd_o;
    logic [7:0]  mem_addr_o;
    logic [15:0] mem_data_i = '0;
    logic        wr_gate_o, erase_gate_o, flux_o, done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [15:0] mem [0:255];
    logic [7:0]  rd_log [0:4095];
    int          rd_n = 0;

    always #4 clk = ~clk;

    disk_field_writer #(.CELL_CLKS(CELL)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .first_i(first_i),
        .count_i(count_i), .addr_i(addr_i), .hold_i(hold_i),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
        .wr_gate_o(wr_gate_o), .erase_gate_o(erase_gate_o),
        .flux_o(flux_o), .done_o(done_o)
    );

    // Memory model: data one cycle after the strobe; every address logged.
    always @(posedge clk) begin
        if (mem_rd_o) begin
            mem_data_i <= mem[mem_addr_o];
            rd_log[rd_n % 4096] <= mem_addr_o;
            rd_n <= rd_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pre_len(input bit first);
        return first ? 34 : 3;
    endfunction

    // 0 preamble, 1 sync, 2 content, 3 postamble
    function automatic int seg_of(input bit first, input int cnt, input int w);
        int p = pre_len(first);
        if (w < p) return 0;
        if (w == p) return 1;
        if (w < p + 1 + cnt) return 2;
        return 3;
    endfunction

    function automatic logic [15:0] exp_word(input bit first, input int cnt, input int addr, input int w);
        int p = pre_len(first);
        case (seg_of(first, cnt, w))
            1: return 16'h0001;
            2: return mem[(addr + w - p - 1) & 255];
            default: return 16'h0000;
        endcase
    endfunction

    task automatic run_record(input bit first, input int cnt, input int addr, input bit hold, input bit poke);
        int nw = pre_len(first) + 1 + cnt + 5;
        int total = nw * WCELL;
        int base = rd_n;
        int e_cell = 0, e_gate = 0, e_done = 0;
        int e_seg [4] = '{0, 0, 0, 0};
        @(negedge clk);
        start_i = 1'b1; first_i = first; count_i = cnt[7:0]; addr_i = addr[7:0]; hold_i = hold;
        @(negedge clk);
        start_i = 1'b0;
        check(wr_gate_o && erase_gate_o && flux_o, "R2 gates and first clock transition", {wr_gate_o, erase_gate_o, flux_o}, 7);
        for (int c = 0; c < total; c++) begin
            int w  = c / WCELL;
            int b  = (c / CELL) % 16;
            int ph = c % CELL;
            logic [15:0] wd = exp_word(first, cnt, addr, w);
            logic ef = (ph == 0) || ((ph == CELL / 2) && wd[15 - b]);
            if (flux_o !== ef) begin
                if (ph == CELL / 2) e_seg[seg_of(first, cnt, w)]++;
                else e_cell++;
            end
            if (!(wr_gate_o && erase_gate_o)) e_gate++;
            if (done_o) e_done++;
            if (poke && c == 500) begin
                start_i = 1'b1; first_i = ~first; count_i = 8'd7; addr_i = 8'd99;
            end
            if (poke && c == 501) start_i = 1'b0;
            @(negedge clk);
        end
        check(e_cell == 0, "R3 cell pulses at offset 0 and off-mid", e_cell, 0);
        check(e_gate == 0, "R2 gates held through record", e_gate, 0);
        check(e_seg[0] == 0, "R4 preamble zero words", e_seg[0], 0);
        check(e_seg[1] == 0, "R5 sync word", e_seg[1], 0);
        check(e_seg[2] == 0, "R6 content words", e_seg[2], 0);
        check(e_seg[3] == 0, "R7 postamble zero words", e_seg[3], 0);
        if (poke) check(e_cell + e_seg[0] + e_seg[1] + e_seg[2] + e_seg[3] == 0,
                        "R9 start during record ignored", e_cell + e_seg[2], 0);
        check(e_done == 0, "R8 done low during record", e_done, 0);
        check(done_o === 1'b1 && flux_o === 1'b0, "R8 done pulse after last cell", {done_o, flux_o}, 2);
        check(wr_gate_o === hold && erase_gate_o === hold, "R8 gates at done follow hold", wr_gate_o, hold);
        @(negedge clk);
        check(done_o === 1'b0, "R8 done lasts one cycle", done_o, 0);
        check(rd_n - base == cnt, "R10 one read per content word", rd_n - base, cnt);
        begin
            int bad = 0;
            for (int i = 0; i < cnt && i < rd_n - base; i++)
                if (rd_log[(base + i) % 4096] != 8'((addr + i) & 255)) bad++;
            check(bad == 0, "R10 sequential read addresses", bad, 0);
        end
        if (hold) begin
            repeat (3) @(negedge clk);
            check(wr_gate_o && erase_gate_o && !flux_o, "R8 held gates stay on", wr_gate_o, 1);
            hold_i = 1'b0;
            @(negedge clk);
            check(!wr_gate_o && !erase_gate_o, "R8 gates drop after hold released", wr_gate_o, 0);
        end
    endtask

    initial begin
        void'($urandom(32'h00c0ffee));
        for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
        mem[10] = 16'hffff; mem[11] = 16'h0000; mem[12] = 16'h8001;
        repeat (3) @(negedge clk);
        check(!wr_gate_o && !erase_gate_o && !flux_o && !done_o && !mem_rd_o,
              "R1 outputs low in reset", {wr_gate_o, flux_o, done_o, mem_rd_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_gate_o && !flux_o && !done_o && !mem_rd_o, "R1 idle after reset",
              {wr_gate_o, flux_o, done_o, mem_rd_o}, 0);
        run_record(1'b1, 3, 10, 1'b0, 1'b0);    // all-ones, all-zero, edge-bit words
        run_record(1'b0, 0, 40, 1'b0, 1'b0);    // no content words
        run_record(1'b0, 1, 255, 1'b1, 1'b1);   // single word, hold, start poke
        run_record(1'b1, 4, 254, 1'b0, 1'b0);   // address wrap
        for (int k = 0; k < 6; k++) begin
            bit f = 1'($urandom % 2);
            int n = int'($urandom % 11);
            int a = int'($urandom % 256);
            bit h = 1'($urandom % 2);
            run_record(f, n, a, h, 1'b0);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R2: actual still running expected record complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule